// File: doc/BRIEF.md
# Cluster Control Register File

This block is the word-addressed control and status register file of a many-core compute cluster. It sits behind a simple single-cycle register bus. A request carries an address, write data, a write flag, byte strobes and a valid bit. Every response carries read data, a ready bit and an error bit in the same cycle as the request.

Software uses the block in several ways. It publishes an end-of-computation word. It wakes every core, one tile or one group by writing to write-only trigger registers. Each trigger hands the written word to the wake-up logic together with a one-cycle qualifier. It can read the memory layout constants of the cluster, which are fixed when the block is elaborated. It also sets the enable, flush and address windows of a read-only cache. The cache window bounds can also be loaded from hardware. A software write to the same window in the same cycle always takes priority.

Top module: `clu_ctrl_regs`

## Requirements
- R1: After reset these values hold: end-of-computation 0, cache enable 1, cache flush 0, every qualifier 0, window start[i] = RGN_BASE + i*RGN_STEP and window end[i] = RGN_BASE + (i+1)*RGN_STEP - 1. With the default parameters these are 0x1000_0000 + i*0x1_0000 and 0x1000_FFFF + i*0x1_0000.
- R2: Registers sit at byte offsets that are multiples of 4. For the defaults (8 tiles, 4 windows) the offsets are: end-of-computation 0x00, global wake 0x04, tile wake[k] 0x08+4k, group wake 0x28, memory start 0x2C, memory end 0x30, core count 0x34, cache enable 0x38, cache flush 0x3C, window start[i] 0x40+4i, window end[i] 0x50+4i.
- R3: rsp_ready_o is 1 in the same cycle as every valid request. Read data appears in that same cycle. A write response returns read data 0.
- R4: The end-of-computation register can be read and written. eoc_o shows the written value from the cycle after the write is accepted.
- R5: The global and group wake registers are write-only and read back 0. In the cycle after a write is accepted, the written word appears on the wake output and its qualifier is 1 for exactly one cycle. The word stays on the output after the qualifier falls.
- R6: Each tile wake entry k is write-only and reads 0. A write to entry k sets only bit k of tile_wake_qe_o for one cycle and places the word in slice k of tile_wake_o.
- R7: Memory start, memory end and core count read back the parameters TCDM_START, TCDM_END and NUM_CORES. A write to them returns no error and changes nothing.
- R8: Cache enable and cache flush can be read and written, and they drive cache_en_o and cache_flush_o from the cycle after the write.
- R9: Window start and end entries can be read and written. A software write updates the entry and raises only that entry's qualifier for one cycle, in the cycle after the write.
- R10: A hardware write strobe loads its entry on the next clock edge and raises no qualifier. If software writes the same entry in the same cycle, the software value is stored.
- R11: An access returns rsp_error_o = 1 in any of these cases: the offset is unmapped, the low two address bits are nonzero, or it is a write whose byte strobes are not all 1. Such an access changes no register and raises no qualifier, and an erroring read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_i | input | AW | Byte address of the request |
| req_wdata_i | input | 32 | Write data |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_strb_i | input | 4 | Byte strobes |
| req_valid_i | input | 1 | Request valid |
| rsp_rdata_o | output | 32 | Read data, same cycle |
| rsp_ready_o | output | 1 | Response ready |
| rsp_error_o | output | 1 | Access error |
| eoc_o | output | 32 | End-of-computation word |
| wake_o | output | 32 | Last global wake word |
| wake_qe_o | output | 1 | Global wake qualifier pulse |
| tile_wake_o | output | 32*NUM_GROUPS | Last tile wake words, entry k in slice k |
| tile_wake_qe_o | output | NUM_GROUPS | Tile wake qualifier pulses |
| group_wake_o | output | 32 | Last group wake word |
| group_wake_qe_o | output | 1 | Group wake qualifier pulse |
| cache_en_o | output | 32 | Cache enable word |
| cache_flush_o | output | 32 | Cache flush word |
| rgn_start_o | output | 32*NUM_RULES | Window start bounds |
| rgn_end_o | output | 32*NUM_RULES | Window end bounds |
| rgn_start_qe_o | output | NUM_RULES | Software write pulses, window start |
| rgn_end_qe_o | output | NUM_RULES | Software write pulses, window end |
| hw_start_we_i | input | NUM_RULES | Hardware load strobes, window start |
| hw_start_d_i | input | 32*NUM_RULES | Hardware load data, window start |
| hw_end_we_i | input | NUM_RULES | Hardware load strobes, window end |
| hw_end_d_i | input | 32*NUM_RULES | Hardware load data, window end |

## Verification
The assertions assume two things about the inputs. Write data and the write flag are held steady for the whole cycle in which valid is high. Hardware load strobes are single-cycle pulses whose data is valid alongside them. The stimulus changes bus and hardware inputs only just after a rising edge, keeps at most one request in each cycle and drops valid between accesses. The simultaneous software and hardware write is driven deliberately in one cycle, so that the priority rule is exercised.

// File: rtl/clu_ctrl_pkg.sv
package clu_ctrl_pkg;

    typedef logic [31:0] word_t;

    // Register classes produced by the address decoder
    typedef enum logic [3:0] {
        K_NONE,
        K_EOC,
        K_WAKE,
        K_TILE,
        K_GROUP,
        K_MSTART,
        K_MEND,
        K_NCORES,
        K_CEN,
        K_CFLUSH,
        K_RSTART,
        K_REND
    } reg_kind_e;

endpackage

// File: rtl/clu_ctrl_decode.sv
module clu_ctrl_decode
    import clu_ctrl_pkg::*;
#(
    parameter int AW         = 8,
    parameter int NUM_GROUPS = 8,
    parameter int NUM_RULES  = 4
) (
    input  logic [AW-1:0]   addr_i,
    output reg_kind_e       kind_o,
    output logic [AW-3:0]   slot_o
);
    localparam int IW = AW - 2;
    localparam logic [IW-1:0] I_TILE0  = IW'(2);
    localparam logic [IW-1:0] I_GROUP  = IW'(2 + NUM_GROUPS);
    localparam logic [IW-1:0] I_MSTART = IW'(3 + NUM_GROUPS);
    localparam logic [IW-1:0] I_MEND   = IW'(4 + NUM_GROUPS);
    localparam logic [IW-1:0] I_NCORES = IW'(5 + NUM_GROUPS);
    localparam logic [IW-1:0] I_CEN    = IW'(6 + NUM_GROUPS);
    localparam logic [IW-1:0] I_CFLUSH = IW'(7 + NUM_GROUPS);
    localparam logic [IW-1:0] I_RS0    = IW'(8 + NUM_GROUPS);
    localparam logic [IW-1:0] I_RE0    = IW'(8 + NUM_GROUPS + NUM_RULES);
    localparam logic [IW-1:0] I_LAST   = IW'(8 + NUM_GROUPS + 2 * NUM_RULES);

    logic [IW-1:0] idx;
    assign idx = addr_i[AW-1:2];

    always_comb begin
        kind_o = K_NONE;
        slot_o = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (idx == IW'(0)) begin
                kind_o = K_EOC;
            end else if (idx == IW'(1)) begin
                kind_o = K_WAKE;
            end else if (idx >= I_TILE0 && idx < I_GROUP) begin
                kind_o = K_TILE;
                slot_o = idx - I_TILE0;
            end else if (idx == I_GROUP) begin
                kind_o = K_GROUP;
            end else if (idx == I_MSTART) begin
                kind_o = K_MSTART;
            end else if (idx == I_MEND) begin
                kind_o = K_MEND;
            end else if (idx == I_NCORES) begin
                kind_o = K_NCORES;
            end else if (idx == I_CEN) begin
                kind_o = K_CEN;
            end else if (idx == I_CFLUSH) begin
                kind_o = K_CFLUSH;
            end else if (idx >= I_RS0 && idx < I_RE0) begin
                kind_o = K_RSTART;
                slot_o = idx - I_RS0;
            end else if (idx >= I_RE0 && idx < I_LAST) begin
                kind_o = K_REND;
                slot_o = idx - I_RE0;
            end
        end
    end

endmodule

// File: rtl/clu_ctrl_rgn_bank.sv
module clu_ctrl_rgn_bank #(
    parameter int          NUM_RULES = 4,
    parameter logic [31:0] RGN_BASE  = 32'h1000_0000,
    parameter logic [31:0] RGN_STEP  = 32'h0001_0000,
    parameter bit          IS_END    = 1'b0
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_RULES-1:0]   sw_we_i,
    input  logic [31:0]            sw_d_i,
    input  logic [NUM_RULES-1:0]   hw_we_i,
    input  logic [32*NUM_RULES-1:0] hw_d_i,
    output logic [32*NUM_RULES-1:0] q_o,
    output logic [NUM_RULES-1:0]   qe_o
);
    for (genvar i = 0; i < NUM_RULES; i++) begin : g_entry
        localparam logic [31:0] RST_VAL = IS_END
            ? RGN_BASE + 32'(i + 1) * RGN_STEP - 32'd1
            : RGN_BASE + 32'(i) * RGN_STEP;

        logic [31:0] val_q;
        logic        qe_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                val_q <= RST_VAL;
                qe_q  <= 1'b0;
            end else begin
                qe_q <= sw_we_i[i];
                if (sw_we_i[i]) begin
                    val_q <= sw_d_i;
                end else if (hw_we_i[i]) begin
                    val_q <= hw_d_i[32*i +: 32];
                end
            end
        end

        assign q_o[32*i +: 32] = val_q;
        assign qe_o[i]         = qe_q;

        AST_SW_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sw_we_i[i] |=> (q_o[32*i +: 32] == $past(sw_d_i)));   // R10

        AST_RGN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!sw_we_i[i] && !hw_we_i[i]) |=> $stable(q_o[32*i +: 32]));   // R9
    end

endmodule

// File: rtl/clu_ctrl_regs.sv
module clu_ctrl_regs
    import clu_ctrl_pkg::*;
#(
    parameter int          AW         = 8,
    parameter int          NUM_GROUPS = 8,
    parameter int          NUM_RULES  = 4,
    parameter logic [31:0] TCDM_START = 32'h0000_0000,
    parameter logic [31:0] TCDM_END   = 32'h0010_0000,
    parameter logic [31:0] NUM_CORES  = 32'd256,
    parameter logic [31:0] RGN_BASE   = 32'h1000_0000,
    parameter logic [31:0] RGN_STEP   = 32'h0001_0000
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [AW-1:0]             req_addr_i,
    input  logic [31:0]               req_wdata_i,
    input  logic                      req_write_i,
    input  logic [3:0]                req_strb_i,
    input  logic                      req_valid_i,
    output logic [31:0]               rsp_rdata_o,
    output logic                      rsp_ready_o,
    output logic                      rsp_error_o,
    output logic [31:0]               eoc_o,
    output logic [31:0]               wake_o,
    output logic                      wake_qe_o,
    output logic [32*NUM_GROUPS-1:0]  tile_wake_o,
    output logic [NUM_GROUPS-1:0]     tile_wake_qe_o,
    output logic [31:0]               group_wake_o,
    output logic                      group_wake_qe_o,
    output logic [31:0]               cache_en_o,
    output logic [31:0]               cache_flush_o,
    output logic [32*NUM_RULES-1:0]   rgn_start_o,
    output logic [32*NUM_RULES-1:0]   rgn_end_o,
    output logic [NUM_RULES-1:0]      rgn_start_qe_o,
    output logic [NUM_RULES-1:0]      rgn_end_qe_o,
    input  logic [NUM_RULES-1:0]      hw_start_we_i,
    input  logic [32*NUM_RULES-1:0]   hw_start_d_i,
    input  logic [NUM_RULES-1:0]      hw_end_we_i,
    input  logic [32*NUM_RULES-1:0]   hw_end_d_i
);
    localparam int IW = AW - 2;

    reg_kind_e     kind;
    logic [IW-1:0] slot;
    logic          full_strb;
    logic          bad_acc;
    logic          wr_ok;
    logic          rd_ok;

    clu_ctrl_decode #(
        .AW         (AW),
        .NUM_GROUPS (NUM_GROUPS),
        .NUM_RULES  (NUM_RULES)
    ) decode_i (
        .addr_i (req_addr_i),
        .kind_o (kind),
        .slot_o (slot)
    );

    assign full_strb = &req_strb_i;
    assign bad_acc   = (kind == K_NONE) || (req_write_i && !full_strb);
    assign wr_ok     = req_valid_i && req_write_i && !bad_acc;
    assign rd_ok     = req_valid_i && !req_write_i && !bad_acc;

    // ---------------- plain software registers ----------------
    word_t eoc_q, wake_q, group_q, cen_q, cfl_q;
    logic  wake_qe_q, group_qe_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eoc_q      <= '0;
            wake_q     <= '0;
            group_q    <= '0;
            cen_q      <= 32'd1;
            cfl_q      <= '0;
            wake_qe_q  <= 1'b0;
            group_qe_q <= 1'b0;
        end else begin
            wake_qe_q  <= wr_ok && (kind == K_WAKE);
            group_qe_q <= wr_ok && (kind == K_GROUP);
            if (wr_ok) begin
                unique case (kind)
                    K_EOC:    eoc_q   <= req_wdata_i;
                    K_WAKE:   wake_q  <= req_wdata_i;
                    K_GROUP:  group_q <= req_wdata_i;
                    K_CEN:    cen_q   <= req_wdata_i;
                    K_CFLUSH: cfl_q   <= req_wdata_i;
                    default:  ;
                endcase
            end
        end
    end

    // ---------------- tile wake triggers ----------------
    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_tile
        word_t tile_q;
        logic  tile_qe_q;
        logic  hit;

        assign hit = wr_ok && (kind == K_TILE) && (slot == IW'(k));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                tile_q    <= '0;
                tile_qe_q <= 1'b0;
            end else begin
                tile_qe_q <= hit;
                if (hit) begin
                    tile_q <= req_wdata_i;
                end
            end
        end

        assign tile_wake_o[32*k +: 32] = tile_q;
        assign tile_wake_qe_o[k]       = tile_qe_q;
    end

    // ---------------- cache window banks ----------------
    logic [NUM_RULES-1:0] rs_swe, re_swe;

    for (genvar i = 0; i < NUM_RULES; i++) begin : g_rwe
        assign rs_swe[i] = wr_ok && (kind == K_RSTART) && (slot == IW'(i));
        assign re_swe[i] = wr_ok && (kind == K_REND)   && (slot == IW'(i));
    end

    clu_ctrl_rgn_bank #(
        .NUM_RULES (NUM_RULES),
        .RGN_BASE  (RGN_BASE),
        .RGN_STEP  (RGN_STEP),
        .IS_END    (1'b0)
    ) start_bank_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sw_we_i (rs_swe),
        .sw_d_i  (req_wdata_i),
        .hw_we_i (hw_start_we_i),
        .hw_d_i  (hw_start_d_i),
        .q_o     (rgn_start_o),
        .qe_o    (rgn_start_qe_o)
    );

    clu_ctrl_rgn_bank #(
        .NUM_RULES (NUM_RULES),
        .RGN_BASE  (RGN_BASE),
        .RGN_STEP  (RGN_STEP),
        .IS_END    (1'b1)
    ) end_bank_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sw_we_i (re_swe),
        .sw_d_i  (req_wdata_i),
        .hw_we_i (hw_end_we_i),
        .hw_d_i  (hw_end_d_i),
        .q_o     (rgn_end_o),
        .qe_o    (rgn_end_qe_o)
    );

    // ---------------- read path ----------------
    word_t rd_val;

    always_comb begin
        rd_val = '0;
        unique case (kind)
            K_EOC:    rd_val = eoc_q;
            K_MSTART: rd_val = TCDM_START;
            K_MEND:   rd_val = TCDM_END;
            K_NCORES: rd_val = NUM_CORES;
            K_CEN:    rd_val = cen_q;
            K_CFLUSH: rd_val = cfl_q;
            K_RSTART: begin
                for (int i = 0; i < NUM_RULES; i++) begin
                    if (slot == IW'(i)) rd_val = rgn_start_o[32*i +: 32];
                end
            end
            K_REND: begin
                for (int i = 0; i < NUM_RULES; i++) begin
                    if (slot == IW'(i)) rd_val = rgn_end_o[32*i +: 32];
                end
            end
            default:  rd_val = '0;
        endcase
    end

    assign rsp_rdata_o = rd_ok ? rd_val : '0;
    assign rsp_ready_o = req_valid_i;
    assign rsp_error_o = req_valid_i && bad_acc;

    assign eoc_o           = eoc_q;
    assign wake_o          = wake_q;
    assign wake_qe_o       = wake_qe_q;
    assign group_wake_o    = group_q;
    assign group_wake_qe_o = group_qe_q;
    assign cache_en_o      = cen_q;
    assign cache_flush_o   = cfl_q;

    // ---------------- assertions ----------------
    AST_WAKE_QE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_qe_o || group_wake_qe_o || (|tile_wake_qe_o))
            |-> $past(req_valid_i && req_write_i && (&req_strb_i)));   // R5

    AST_WAKE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_qe_o |-> (wake_o == $past(req_wdata_i)));   // R5

    AST_TILE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(tile_wake_qe_o));   // R6

    AST_ERR_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_error_o |=> (!wake_qe_o && !group_wake_qe_o && (tile_wake_qe_o == '0)
                         && (rgn_start_qe_o == '0) && (rgn_end_qe_o == '0)
                         && $stable(eoc_o) && $stable(cache_en_o)
                         && $stable(cache_flush_o)));   // R11

    AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_error_o |-> (rsp_rdata_o == '0));   // R11

endmodule

// File: tb/clu_ctrl_regs_tb_top.sv
module clu_ctrl_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NG = 8;
    localparam int NR = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_write = 1'b0;
    logic [3:0]        req_strb = '0;
    logic              req_valid = 1'b0;
    logic [31:0]       rsp_rdata;
    logic              rsp_ready, rsp_error;
    logic [31:0]       eoc, wake, group_wake, cache_en, cache_flush;
    logic              wake_qe, group_qe;
    logic [32*NG-1:0]  tile_wake;
    logic [NG-1:0]     tile_qe;
    logic [32*NR-1:0]  rgn_start, rgn_end;
    logic [NR-1:0]     rs_qe, re_qe;
    logic [NR-1:0]     hw_s_we = '0, hw_e_we = '0;
    logic [32*NR-1:0]  hw_s_d = '0, hw_e_d = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_data[$];
    logic        exp_err[$];
    string       exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    clu_ctrl_regs #(.AW(AW), .NUM_GROUPS(NG), .NUM_RULES(NR)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_write_i(req_write),
        .req_strb_i(req_strb), .req_valid_i(req_valid),
        .rsp_rdata_o(rsp_rdata), .rsp_ready_o(rsp_ready), .rsp_error_o(rsp_error),
        .eoc_o(eoc), .wake_o(wake), .wake_qe_o(wake_qe),
        .tile_wake_o(tile_wake), .tile_wake_qe_o(tile_qe),
        .group_wake_o(group_wake), .group_wake_qe_o(group_qe),
        .cache_en_o(cache_en), .cache_flush_o(cache_flush),
        .rgn_start_o(rgn_start), .rgn_end_o(rgn_end),
        .rgn_start_qe_o(rs_qe), .rgn_end_qe_o(re_qe),
        .hw_start_we_i(hw_s_we), .hw_start_d_i(hw_s_d),
        .hw_end_we_i(hw_e_we), .hw_end_d_i(hw_e_d)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compares each response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            if (exp_data.size() == 0) begin
                check(1'b0, "scoreboard empty", 32'd0, 32'd1);
            end else begin
                logic [31:0] d;
                logic        e;
                string       t;
                d = exp_data.pop_front();
                e = exp_err.pop_front();
                t = exp_tag.pop_front();
                check(rsp_ready == 1'b1, {"R3 ready ", t}, 32'(rsp_ready), 32'd1);
                check(rsp_error == e, {t, " error"}, 32'(rsp_error), 32'(e));
                check(rsp_rdata == d, {t, " rdata"}, rsp_rdata, d);
            end
        end
    end

    task automatic drive(input logic [AW-1:0] a, input logic [31:0] wd, input bit w,
                         input logic [3:0] s, input logic [31:0] ed, input bit ee,
                         input string tag);
        @(posedge clk); #1;
        req_addr = a; req_wdata = wd; req_write = w; req_strb = s; req_valid = 1'b1;
        exp_data.push_back(ed); exp_err.push_back(ee); exp_tag.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0; req_strb = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] ed, input bit ee,
                      input string tag);
        drive(a, 32'd0, 1'b0, 4'h0, ed, ee, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] wd, input logic [3:0] s,
                      input bit ee, input string tag);
        drive(a, wd, 1'b1, s, 32'd0, ee, tag);
    endtask

    function automatic logic [31:0] rs_rst(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0001_0000;
    endfunction

    function automatic logic [31:0] re_rst(input int i);
        return 32'h1000_FFFF + 32'(i) * 32'h0001_0000;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd20000, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check(eoc == 0, "R1 eoc reset", eoc, 0);
        check(cache_en == 1, "R1 cache enable reset", cache_en, 1);
        check(cache_flush == 0, "R1 flush reset", cache_flush, 0);
        check({wake_qe, group_qe, tile_qe, rs_qe, re_qe} == '0, "R1 qualifiers reset",
              32'({wake_qe, group_qe, tile_qe, rs_qe, re_qe}), 0);
        check(rgn_start[32*1 +: 32] == rs_rst(1), "R1 start[1] reset",
              rgn_start[32*1 +: 32], rs_rst(1));
        check(rgn_end[32*3 +: 32] == re_rst(3), "R1 end[3] reset",
              rgn_end[32*3 +: 32], re_rst(3));

        // R1 R2 reset values through the map
        rd(8'h00, 32'd0, 1'b0, "R2 eoc read");
        rd(8'h38, 32'd1, 1'b0, "R2 cache enable read");
        rd(8'h3C, 32'd0, 1'b0, "R2 flush read");
        for (int i = 0; i < NR; i++) begin
            rd(8'(8'h40 + 4*i), rs_rst(i), 1'b0, "R2 start read");
            rd(8'(8'h50 + 4*i), re_rst(i), 1'b0, "R2 end read");
        end

        // R7 layout constants and ignored writes
        rd(8'h2C, 32'h0000_0000, 1'b0, "R7 mem start");
        rd(8'h30, 32'h0010_0000, 1'b0, "R7 mem end");
        rd(8'h34, 32'd256, 1'b0, "R7 core count");
        wr(8'h34, 32'h5, 4'hF, 1'b0, "R7 write core count");
        wr(8'h30, 32'h77, 4'hF, 1'b0, "R7 write mem end");
        rd(8'h34, 32'd256, 1'b0, "R7 core count after write");
        rd(8'h30, 32'h0010_0000, 1'b0, "R7 mem end after write");

        // R4 end of computation
        wr(8'h00, 32'hDEAD_BEEF, 4'hF, 1'b0, "R4 eoc write");
        check(eoc == 32'hDEAD_BEEF, "R4 eoc_o", eoc, 32'hDEAD_BEEF);
        rd(8'h00, 32'hDEAD_BEEF, 1'b0, "R4 eoc readback");

        // R5 global wake
        wr(8'h04, 32'h0000_0003, 4'hF, 1'b0, "R5 wake write");
        check(wake_qe == 1'b1, "R5 wake qe high", 32'(wake_qe), 1);
        check(wake == 32'h3, "R5 wake word", wake, 32'h3);
        @(posedge clk); #1;
        check(wake_qe == 1'b0, "R5 wake qe one cycle", 32'(wake_qe), 0);
        check(wake == 32'h3, "R5 wake word held", wake, 32'h3);
        rd(8'h04, 32'd0, 1'b0, "R5 wake reads zero");

        // R5 group wake
        wr(8'h28, 32'hA5, 4'hF, 1'b0, "R5 group write");
        check(group_qe == 1'b1 && group_wake == 32'hA5, "R5 group qe/word",
              group_wake, 32'hA5);
        @(posedge clk); #1;
        check(group_qe == 1'b0, "R5 group qe one cycle", 32'(group_qe), 0);
        rd(8'h28, 32'd0, 1'b0, "R5 group reads zero");

        // R6 tile wake entries
        wr(8'h1C, 32'h55, 4'hF, 1'b0, "R6 tile5 write");
        check(tile_qe == 8'b0010_0000, "R6 tile5 qe", 32'(tile_qe), 32'h20);
        check(tile_wake[32*5 +: 32] == 32'h55, "R6 tile5 word", tile_wake[32*5 +: 32], 32'h55);
        @(posedge clk); #1;
        check(tile_qe == 8'h00, "R6 tile qe one cycle", 32'(tile_qe), 0);
        wr(8'h08, 32'h11, 4'hF, 1'b0, "R6 tile0 write");
        check(tile_qe == 8'b0000_0001, "R6 tile0 qe", 32'(tile_qe), 32'h1);
        rd(8'h1C, 32'd0, 1'b0, "R6 tile reads zero");

        // R8 cache enable and flush
        wr(8'h38, 32'h0, 4'hF, 1'b0, "R8 enable write");
        wr(8'h3C, 32'h1, 4'hF, 1'b0, "R8 flush write");
        check(cache_en == 0 && cache_flush == 1, "R8 cache outputs",
              {cache_en[15:0], cache_flush[15:0]}, 32'h0000_0001);
        rd(8'h38, 32'd0, 1'b0, "R8 enable readback");
        rd(8'h3C, 32'd1, 1'b0, "R8 flush readback");

        // R9 window software write
        wr(8'h48, 32'h2222_0000, 4'hF, 1'b0, "R9 start2 write");
        check(rs_qe == 4'b0100 && re_qe == 4'b0000, "R9 start2 qe", 32'({rs_qe, re_qe}), 32'h40);
        check(rgn_start[32*2 +: 32] == 32'h2222_0000, "R9 start2 value",
              rgn_start[32*2 +: 32], 32'h2222_0000);
        @(posedge clk); #1;
        check(rs_qe == 4'b0000, "R9 start qe one cycle", 32'(rs_qe), 0);
        rd(8'h48, 32'h2222_0000, 1'b0, "R9 start2 readback");
        wr(8'h5C, 32'h3333_FFFF, 4'hF, 1'b0, "R9 end3 write");
        check(re_qe == 4'b1000, "R9 end3 qe", 32'(re_qe), 32'h8);
        rd(8'h5C, 32'h3333_FFFF, 1'b0, "R9 end3 readback");

        // R10 hardware load
        @(posedge clk); #1;
        hw_e_we = 4'b0010; hw_e_d[32*1 +: 32] = 32'h4444_4444;
        @(posedge clk); #1;
        hw_e_we = '0;
        check(re_qe == 4'b0000, "R10 hw load no qe", 32'(re_qe), 0);
        check(rgn_end[32*1 +: 32] == 32'h4444_4444, "R10 hw load value",
              rgn_end[32*1 +: 32], 32'h4444_4444);
        rd(8'h54, 32'h4444_4444, 1'b0, "R10 hw load readback");

        // R10 software wins over a same-cycle hardware load
        @(posedge clk); #1;
        req_addr = 8'h40; req_wdata = 32'hABCD_0000; req_write = 1'b1;
        req_strb = 4'hF; req_valid = 1'b1;
        hw_s_we = 4'b0001; hw_s_d[31:0] = 32'h9999_9999;
        exp_data.push_back(32'd0); exp_err.push_back(1'b0); exp_tag.push_back("R10 collide");
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0; req_strb = '0; hw_s_we = '0;
        check(rs_qe == 4'b0001, "R10 collide qe", 32'(rs_qe), 1);
        rd(8'h40, 32'hABCD_0000, 1'b0, "R10 software priority");

        // R11 errors without effect
        rd(8'h60, 32'd0, 1'b1, "R11 unmapped read");
        wr(8'h60, 32'h1, 4'hF, 1'b1, "R11 unmapped write");
        rd(8'h01, 32'd0, 1'b1, "R11 misaligned read");
        wr(8'h00, 32'h1234_5678, 4'h3, 1'b1, "R11 partial eoc write");
        check(eoc == 32'hDEAD_BEEF, "R11 eoc unchanged", eoc, 32'hDEAD_BEEF);
        wr(8'h04, 32'hF0, 4'h7, 1'b1, "R11 partial wake write");
        check(wake_qe == 1'b0 && wake == 32'h3, "R11 wake no qe", wake, 32'h3);
        wr(8'h44, 32'hFFFF_FFFF, 4'hE, 1'b1, "R11 partial start write");
        check(rs_qe == 4'b0000, "R11 start no qe", 32'(rs_qe), 0);
        rd(8'h44, rs_rst(1), 1'b0, "R11 start1 unchanged");

        repeat (3) @(posedge clk);
        #1;
        check(exp_data.size() == 0, "R3 all responses seen", 32'(exp_data.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule